// File: doc/BRIEF.md
# Lockable SMI Enable Controller

This block decides whether system management interrupts leave the power-management unit. Event lines from several sources set latched status flags. A flag whose source is enabled becomes pending, and pending work turns into an SMI pulse only while a global enable is on. Firmware can set a one-way lock that freezes the global enable until platform reset. After that, software can no longer switch SMIs on or off.

A 32-bit counter of delivered SMIs lets software check whether a lock-down really stopped the interrupts. Registers are reached through a simple 32-bit read/write port with byte offsets. Reads are combinational and writes take effect at the next clock edge. The platform reset `rst_n` is active low.

Top module: `smi_lockdown_top`

## Requirements
- R1: After platform reset, every register reads 0 and `smi_o` is low.
- R2: Writing 1 to bit 4 at offset 0x24 sets the lock. Writing 0 to it has no effect, and only platform reset clears it. All other bits at 0x24 read 0.
- R3: While the lock is 1, writes to bit 0 at offset 0x30 (global enable) are ignored in both directions.
- R4: While the global enable is 0, `smi_o` stays low whatever the source enables and status flags are.
- R5: At offset 0x30, bit 0 is the global enable and bits NUM_SRC..1 enable sources 0..NUM_SRC-1. Bit 1 (source 0) can only be set by a write; writing 0 leaves it unchanged. After 0x33 is written, a write of 0 reads back as 0x02.
- R6: At offset 0x34, bit i is set by a high `evt_in[i]` and cleared by writing 1 to it. Writing 0 leaves it unchanged. An event and a clear in the same cycle leave the bit set.
- R7: `smi_o` is a one-cycle pulse. It is issued one cycle after an enabled status flag becomes pending while the global enable is 1. It is not issued again until every enabled pending flag has been cleared.
- R8: Offset 0x38 reads the count of SMI pulses since reset. The count rises by one per pulse and ignores writes.
- R9: Reads of any other offset return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | NUM_SRC | Event lines, one per source |
| smi_o | output | 1 | SMI pulse |

## Verification
The hardest case is a source that is already pending, where a second event or a partial clear must not produce a new pulse. The stimulus leaves one enabled flag set and fires it again. It also sets a flag on a disabled source. It then clears only the enabled flag and re-fires it, which must give exactly one new pulse and raise the count to two. A separate scenario drives an event and its clear in the same cycle.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 8;
    localparam logic [ADDR_W-1:0] OFF_CFG = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_EN  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_STS = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_CNT = 8'h38;
    localparam int LOCK_BIT   = 4;
    localparam int GBL_BIT    = 0;
endpackage

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
    import smi_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cfg,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wdata,
    output logic               lock_o,
    output logic               gbl_o,
    output logic [NUM_SRC-1:0] src_en_o
);
    typedef struct packed {
        logic               lock;
        logic               gbl;
        logic [NUM_SRC-1:0] src_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_cfg && wdata[LOCK_BIT]) begin
            cfg_d.lock = 1'b1;
        end
        if (wr_en) begin
            if (!cfg_q.lock) begin
                cfg_d.gbl = wdata[GBL_BIT];
            end
            cfg_d.src_en[0] = cfg_q.src_en[0] | wdata[1];
            cfg_d.src_en[NUM_SRC-1:1] = wdata[NUM_SRC:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lock_o   = cfg_q.lock;
    assign gbl_o    = cfg_q.gbl;
    assign src_en_o = cfg_q.src_en;

    // R2: lock only ever sets
    a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> cfg_q.lock);
    // R3: frozen global enable
    a_r3_gbl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> $stable(cfg_q.gbl));
    // R5: source 0 enable is set-only
    a_r5_src0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.src_en[0] |=> cfg_q.src_en[0]);
endmodule

// File: rtl/smi_event_core.sv
module smi_event_core
    import smi_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               wr_sts,
    input  logic [REG_W-1:0]   wdata,
    input  logic               gbl,
    input  logic [NUM_SRC-1:0] src_en,
    output logic [NUM_SRC-1:0] status_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               smi_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic               served;
        logic               smi;
        logic [CNT_W-1:0]   count;
    } core_t;

    core_t core_d, core_q;
    logic [NUM_SRC-1:0] clr_mask;
    logic               pending;
    logic               fire;

    always_comb begin
        clr_mask = wr_sts ? wdata[NUM_SRC-1:0] : '0;
        pending  = gbl && |(core_q.status & src_en);
        fire     = pending && !core_q.served;
        core_d        = core_q;
        core_d.status = (core_q.status & ~clr_mask) | evt;
        core_d.served = pending;
        core_d.smi    = fire;
        core_d.count  = core_q.count + CNT_W'(fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign status_o = core_q.status;
    assign count_o  = core_q.count;
    assign smi_o    = core_q.smi;

    // R7: pulse lasts one cycle
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.smi |=> !core_q.smi);
    // R4: global enable gates output
    a_r4_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gbl |=> !core_q.smi);
    // R6: an event always lands in status
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((core_q.status & $past(evt)) == $past(evt)));
    // R8: count steps with each pulse and holds otherwise
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.smi |-> (core_q.count == $past(core_q.count) + 1'b1));
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !core_q.smi |-> $stable(core_q.count));
endmodule

// File: rtl/smi_lockdown_top.sv
module smi_lockdown_top
    import smi_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               smi_o
);
    logic               wr_cfg, wr_en, wr_sts;
    logic               lock, gbl;
    logic [NUM_SRC-1:0] src_en, status;
    logic [CNT_W-1:0]   count;

    always_comb begin
        wr_cfg = reg_wr && (reg_addr == OFF_CFG);
        wr_en  = reg_wr && (reg_addr == OFF_EN);
        wr_sts = reg_wr && (reg_addr == OFF_STS);
    end

    smi_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (wr_cfg),
        .wr_en    (wr_en),
        .wdata    (reg_wdata),
        .lock_o   (lock),
        .gbl_o    (gbl),
        .src_en_o (src_en)
    );

    smi_event_core #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_in),
        .wr_sts   (wr_sts),
        .wdata    (reg_wdata),
        .gbl      (gbl),
        .src_en   (src_en),
        .status_o (status),
        .count_o  (count),
        .smi_o    (smi_o)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CFG: reg_rdata[LOCK_BIT] = lock;
            OFF_EN: begin
                reg_rdata[GBL_BIT]     = gbl;
                reg_rdata[NUM_SRC:1]   = src_en;
            end
            OFF_STS: reg_rdata[NUM_SRC-1:0] = status;
            OFF_CNT: reg_rdata[CNT_W-1:0]   = count;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/smi_lockdown_top_test.sv
module smi_lockdown_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  evt_in = '0;
    logic        smi_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smi_lockdown_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .smi_o(smi_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; reg_wr = 1'b0; evt_in = '0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic fire(input logic [5:0] m);
        @(negedge clk); evt_in = m;
        @(negedge clk); evt_in = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(8'h24, v); check("R1 cfg", v, 0);
        rd(8'h30, v); check("R1 en", v, 0);
        rd(8'h34, v); check("R1 sts", v, 0);
        rd(8'h38, v); check("R1 cnt", v, 0);
        check("R1 smi", smi_o, 0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); check("R2 lock set, other bits 0", v, 32'h10);
        wr(8'h24, 32'h0);
        rd(8'h24, v); check("R2 lock holds on 0", v, 32'h10);
        do_reset();
        rd(8'h24, v); check("R2 reset clears lock", v, 0);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        do_reset();
        wr(8'h30, 32'h1); wr(8'h24, 32'h10); wr(8'h30, 32'h0);
        rd(8'h30, v); check("R3 gbl stays 1", v, 32'h1);
        do_reset();
        wr(8'h24, 32'h10); wr(8'h30, 32'h5);
        rd(8'h30, v); check("R3 gbl stays 0, src bits written", v, 32'h4);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        do_reset();
        wr(8'h30, 32'h33);
        rd(8'h30, v); check("R5 write 0x33", v, 32'h33);
        wr(8'h30, 32'h0);
        rd(8'h30, v); check("R5 zero write keeps bit1", v, 32'h02);
    endtask

    task automatic t_gated();
        logic [31:0] v;
        int seen = 0;
        do_reset();
        wr(8'h30, 32'h7E);
        @(negedge clk); evt_in = 6'h3F;
        @(negedge clk); evt_in = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); if (smi_o) seen++;
        end
        check("R4 no smi with gbl 0", seen, 0);
        rd(8'h38, v); check("R4 count stays 0", v, 0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        do_reset();
        fire(6'h04);
        rd(8'h34, v); check("R6 event sets bit2", v, 32'h4);
        wr(8'h34, 32'h0);
        rd(8'h34, v); check("R6 zero write keeps", v, 32'h4);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h34; reg_wdata = 32'h4; evt_in = 6'h04;
        @(negedge clk); reg_wr = 1'b0; evt_in = '0;
        rd(8'h34, v); check("R6 event beats clear", v, 32'h4);
        wr(8'h34, 32'h4);
        rd(8'h34, v); check("R6 W1C clears", v, 0);
    endtask

    task automatic t_pulse();
        logic [31:0] v;
        int seen = 0;
        do_reset();
        wr(8'h30, 32'h5);
        fire(6'h02);
        check("R7 no smi yet", smi_o, 0);
        @(negedge clk); check("R7 smi pulse", smi_o, 1);
        @(negedge clk); check("R7 pulse one cycle", smi_o, 0);
        fire(6'h02); fire(6'h08);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); if (smi_o) seen++;
        end
        check("R7 no re-issue while pending", seen, 0);
        wr(8'h34, 32'h2);
        fire(6'h02);
        @(negedge clk); check("R7 re-issue after clear", smi_o, 1);
        @(negedge clk);
        rd(8'h38, v); check("R8 count two", v, 2);
        wr(8'h38, 32'hFFFF);
        rd(8'h38, v); check("R8 count read-only", v, 2);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_reset();
        wr(8'h30, 32'h3);
        wr(8'h28, 32'hFFFF_FFFF); wr(8'h31, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R9 unmapped read 0", v, 0);
        rd(8'h40, v); check("R9 unmapped read 0 far", v, 0);
        rd(8'h24, v); check("R9 cfg untouched", v, 0);
        rd(8'h30, v); check("R9 en untouched", v, 32'h3);
        rd(8'h34, v); check("R9 sts untouched", v, 0);
    endtask

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lock();
        t_freeze();
        t_layout();
        t_gated();
        t_status();
        t_pulse();
        t_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule